// File: doc/BRIEF.md
# Packet Injection Rate Regulator

This block sits between a packet source and the injection port of an on-chip network. It shapes the traffic that enters the network so that a guaranteed-service analysis of that network stays valid. Two limits are enforced together. A long-term average flit rate is enforced by a credit bucket that earns a fractional amount each cycle. A peak rate is enforced by a minimum number of idle cycles between successive flits. Every packet is also checked against a configured length window, and a packet outside that window is removed from the stream.

Packets arrive as flit streams. The head flit of each packet carries the packet length in flits on a side input. Packets leave through a registered valid/ready output that marks the final flit of each packet. A bypass input switches the block into best-effort mode. In that mode flits move whenever the output can take them, and both rate limits are ignored. The length window is enforced in both modes. The configuration inputs are expected to change only while reset is asserted.

Top module: `rir_regulator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid and len_err are 0. The credit bucket starts empty, so with cfg_rate = 0 in regulated mode a valid length head is never accepted (in_ready stays 0).
- R2: With cfg_bypass = 1, a flit of an in-window packet is accepted whenever the output register is free, whatever cfg_rate and cfg_gap are. It appears on out_data one cycle after acceptance, so a continuous source with out_ready = 1 yields one flit per cycle.
- R3: A packet is dropped whole when its in_len (flit count including the head, sampled on the head flit) is 0, below cfg_min_len or above cfg_max_len. All of its flits are accepted (a zero-length head consumes only itself) and none reaches the output. A packet whose length equals cfg_min_len or cfg_max_len passes.
- R4: len_err goes to 1 in the cycle after a dropped head is accepted, in either mode. It stays 1 until reset and is never set by an in-window packet.
- R5: In regulated mode, two successive forwarded flits are accepted at least cfg_gap + 1 cycles apart. With a continuous source, ample credit and out_ready = 1, flits inside a packet leave exactly cfg_gap + 1 cycles apart.
- R6: In regulated mode the bucket gains cfg_rate / 2^FRAC_W flits of credit per cycle, saturating at cfg_burst flits. The number of forwarded flits after n cycles from reset never exceeds n * cfg_rate / 2^FRAC_W + 1.
- R7: In regulated mode a head is accepted only when the credit is at least in_len, and acceptance removes in_len of credit. Starting empty with cfg_rate = 64 (FRAC_W = 8), a 4-flit packet first appears about 17 cycles after reset, and a second 4-flit packet starts about 16 cycles after the first.
- R8: Once a packet's head is accepted, its remaining flits wait only for the peak gap and the output register, never for credit, so a packet is never split by the average-rate limit.
- R9: While out_valid = 1 and out_ready = 0, out_valid, out_data and out_last hold their values. out_last = 1 marks the final flit of each forwarded packet.
- R10: Forwarded flits leave in arrival order with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bypass | input | 1 | 1 = best-effort mode, rate limits ignored |
| cfg_rate | input | FRAC_W+1 | Credit earned per cycle, in 1/2^FRAC_W flit units |
| cfg_burst | input | LEN_W | Bucket depth in flits |
| cfg_gap | input | GAP_W | Minimum idle cycles between forwarded flits |
| cfg_min_len | input | LEN_W | Smallest allowed packet length in flits |
| cfg_max_len | input | LEN_W | Largest allowed packet length in flits |
| in_valid | input | 1 | Source flit valid |
| in_ready | output | 1 | Regulator accepts the flit this cycle |
| in_data | input | DATA_W | Source flit |
| in_len | input | LEN_W | Packet length in flits, meaningful on the head flit |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Network port takes the flit |
| out_data | output | DATA_W | Output flit |
| out_last | output | 1 | Output flit is the last of its packet |
| len_err | output | 1 | Sticky: a packet was dropped for its length |

## Verification
The assertions rely on three assumptions about the inputs. The configuration does not change while reset is low. in_len is valid on every head flit. The peak-gap property only applies when bypass is off for the whole run. The bench meets these by setting each configuration while reset is held and re-applying reset before every new configuration. Its driver holds each flit with its length until in_ready is seen, and it changes out_ready only just after a clock edge. Random lengths include zero and values on both sides of the window. Random backpressure runs in both modes, and directed cases cover the credit delay, the gap spacing and the bypass passing through a zero rate.

// File: rtl/rir_pkg.sv
package rir_pkg;
  typedef enum logic [1:0] {
    ST_HEAD = 2'd0,
    ST_FWD  = 2'd1,
    ST_DUMP = 2'd2
  } rir_state_e;
endpackage

// File: rtl/rir_bucket.sv
module rir_bucket #(
  parameter int LEN_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W:0]   rate,
  input  logic [LEN_W-1:0]  burst,
  input  logic              spend_en,
  input  logic [LEN_W-1:0]  want_len,
  output logic              enough
);
  localparam int CW = LEN_W + FRAC_W;

  logic [CW-1:0] credit;
  logic [CW:0]   sum;
  logic [CW:0]   cap;
  logic [CW:0]   cost;

  always_comb begin
    cap  = {1'b0, burst, {FRAC_W{1'b0}}};
    cost = spend_en ? {1'b0, want_len, {FRAC_W{1'b0}}} : '0;
    sum  = {1'b0, credit} - cost + {{LEN_W{1'b0}}, rate};
  end

  assign enough = ({1'b0, credit} >= {1'b0, want_len, {FRAC_W{1'b0}}});

  always_ff @(posedge clk) begin
    if (rst) begin
      credit <= '0;
    end else if (sum > cap) begin
      credit <= cap[CW-1:0];
    end else begin
      credit <= sum[CW-1:0];
    end
  end
endmodule

// File: rtl/rir_gap.sv
module rir_gap #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  output logic             open
);
  logic [GAP_W-1:0] cnt;

  assign open = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= gap;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rir_ctrl.sv
module rir_ctrl
  import rir_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic [LEN_W-1:0] min_len,
  input  logic [LEN_W-1:0] max_len,
  input  logic             in_valid,
  input  logic [LEN_W-1:0] in_len,
  input  logic             credit_ok,
  input  logic             gap_open,
  input  logic             out_free,
  output logic             in_ready,
  output logic             fwd_fire,
  output logic             spend,
  output logic             tail,
  output logic             err
);
  rir_state_e       state;
  logic [LEN_W-1:0] left;
  logic             bad_len;
  logic             fire;

  assign bad_len = (in_len == '0) || (in_len < min_len) || (in_len > max_len);

  always_comb begin
    in_ready = 1'b0;
    tail     = 1'b0;
    case (state)
      ST_HEAD: begin
        tail = (in_len == LEN_W'(1));
        if (bad_len) in_ready = 1'b1;
        else         in_ready = out_free && (bypass || (gap_open && credit_ok));
      end
      ST_FWD: begin
        tail     = (left == LEN_W'(1));
        in_ready = out_free && (bypass || gap_open);
      end
      default: in_ready = 1'b1;
    endcase
  end

  assign fire     = in_valid && in_ready;
  assign fwd_fire = fire && ((state == ST_FWD) || (state == ST_HEAD && !bad_len));
  assign spend    = fire && (state == ST_HEAD) && !bad_len && !bypass;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HEAD;
      left  <= '0;
      err   <= 1'b0;
    end else if (fire) begin
      case (state)
        ST_HEAD: begin
          if (bad_len) err <= 1'b1;
          if (in_len > LEN_W'(1)) begin
            left  <= in_len - 1'b1;
            state <= bad_len ? ST_DUMP : ST_FWD;
          end
        end
        default: begin
          left <= left - 1'b1;
          if (left == LEN_W'(1)) state <= ST_HEAD;
        end
      endcase
    end
  end
endmodule

// File: rtl/rir_regulator.sv
module rir_regulator #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int FRAC_W = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bypass,
  input  logic [FRAC_W:0]   cfg_rate,
  input  logic [LEN_W-1:0]  cfg_burst,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [LEN_W-1:0]  cfg_min_len,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              len_err
);
  logic credit_ok;
  logic gap_open;
  logic out_free;
  logic fwd_fire;
  logic spend;
  logic tail;

  assign out_free = !out_valid || out_ready;

  rir_bucket #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) i_bucket (
    .clk(clk), .rst(rst), .rate(cfg_rate), .burst(cfg_burst),
    .spend_en(spend), .want_len(in_len), .enough(credit_ok)
  );

  rir_gap #(.GAP_W(GAP_W)) i_gap (
    .clk(clk), .rst(rst), .load(fwd_fire), .gap(cfg_gap), .open(gap_open)
  );

  rir_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rst(rst), .bypass(cfg_bypass),
    .min_len(cfg_min_len), .max_len(cfg_max_len),
    .in_valid(in_valid), .in_len(in_len),
    .credit_ok(credit_ok), .gap_open(gap_open), .out_free(out_free),
    .in_ready(in_ready), .fwd_fire(fwd_fire), .spend(spend),
    .tail(tail), .err(len_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (fwd_fire) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_last  <= tail;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rir_checker.sv
module rir_checker #(
  parameter int DATA_W = 32,
  parameter int GAP_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_bypass,
  input logic [GAP_W-1:0]  cfg_gap,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              len_err,
  input logic              fwd_fire
);
  logic [GAP_W:0] since;
  logic           seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (fwd_fire) begin
      since <= '0;
      seen  <= 1'b1;
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  // R9: output holds under backpressure
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R4: error flag is sticky
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    len_err |=> len_err);

  // R4: error rises only after an accepted input flit
  assert_err_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(len_err) |-> $past(in_valid && in_ready));

  // R5: forwarded flits respect the peak gap in regulated mode
  assert_peak_gap_R5: assert property (@(posedge clk) disable iff (rst)
    fwd_fire && seen && !cfg_bypass |-> since >= {1'b0, cfg_gap});

  // R9: output drops only after it was taken
  assert_out_taken_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_ready));
endmodule

bind rir_regulator rir_checker #(.DATA_W(DATA_W), .GAP_W(GAP_W)) i_chk (
  .clk(clk), .rst(rst), .cfg_bypass(cfg_bypass), .cfg_gap(cfg_gap),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .len_err(len_err), .fwd_fire(fwd_fire)
);

// File: tb/test_rir_regulator.sv
module test_rir_regulator;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 8;
  localparam int FRAC_W = 8;
  localparam int GAP_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_bypass = 1'b0;
  logic [FRAC_W:0]   cfg_rate = '0;
  logic [LEN_W-1:0]  cfg_burst = '0;
  logic [GAP_W-1:0]  cfg_gap = '0;
  logic [LEN_W-1:0]  cfg_min_len = 8'd1;
  logic [LEN_W-1:0]  cfg_max_len = 8'd16;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic [LEN_W-1:0]  in_len = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [DATA_W-1:0] out_data;
  logic              out_last;
  logic              len_err;

  rir_regulator #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FRAC_W(FRAC_W), .GAP_W(GAP_W)) i_rir_regulator (
    .clk(clk), .rst(rst), .cfg_bypass(cfg_bypass), .cfg_rate(cfg_rate),
    .cfg_burst(cfg_burst), .cfg_gap(cfg_gap), .cfg_min_len(cfg_min_len),
    .cfg_max_len(cfg_max_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_len(in_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .len_err(len_err)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rel_cyc = 0;
  int n_out = 0;
  int prev_cyc = 0;
  bit prev_last = 1'b1;
  bit chk_space = 1'b0;
  int exp_space = 1;
  bit rate_chk = 1'b0;
  bit rand_ready = 1'b0;
  bit hold_pend = 1'b0;
  bit bad_sent = 1'b0;
  logic [DATA_W:0] hold_val;
  logic [DATA_W:0] exp_q[$];
  int heads[$];

  task automatic check_eq(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_rng(string tag, longint act, longint lo, longint hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  function automatic bit len_ok(int len);
    return (len >= 1) && (len >= int'(cfg_min_len)) && (len <= int'(cfg_max_len));
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    out_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        check_eq("R9 hold valid", longint'(out_valid), 1);
        check_eq("R9 hold data", longint'({out_last, out_data}), longint'(hold_val));
      end
      hold_pend = out_valid && !out_ready;
      hold_val  = {out_last, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check_eq("R10 unexpected flit", longint'(out_data), -1);
        end else begin
          check_eq("R10 flit order", longint'({out_last, out_data}), longint'(exp_q.pop_front()));
        end
        if (chk_space && !prev_last)
          check_eq("R5 R8 spacing in packet", cyc - prev_cyc, exp_space);
        if (prev_last) heads.push_back(cyc - rel_cyc);
        prev_cyc  = cyc;
        prev_last = out_last;
        n_out++;
        if (rate_chk)
          check_rng("R6 average rate bound", longint'(n_out) * 256, 0,
                    longint'(cyc - rel_cyc) * int'(cfg_rate) + 256);
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1 reset out_valid", longint'(out_valid), 0);
    check_eq("R1 reset len_err", longint'(len_err), 0);
    exp_q.delete();
    heads.delete();
    n_out = 0;
    prev_last = 1'b1;
    hold_pend = 1'b0;
    bad_sent = 1'b0;
    rst = 1'b0;
    rel_cyc = cyc;
  endtask

  task automatic send_pkt(int len, int id);
    int nfl;
    bit good;
    good = len_ok(len);
    nfl = (len == 0) ? 1 : len;
    if (!good) bad_sent = 1'b1;
    for (int i = 0; i < nfl; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {id[15:0], i[15:0]};
      in_len   = len[LEN_W-1:0];
      if (good) exp_q.push_back({(i == nfl - 1), id[15:0], i[15:0]});
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3000 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    check_eq("R10 all flits delivered", exp_q.size(), 0);
  endtask

  task automatic set_cfg(bit byp, int rate, int burst, int gap, int mn, int mx);
    rst = 1'b1;
    cfg_bypass  = byp;
    cfg_rate    = rate[FRAC_W:0];
    cfg_burst   = burst[LEN_W-1:0];
    cfg_gap     = gap[GAP_W-1:0];
    cfg_min_len = mn[LEN_W-1:0];
    cfg_max_len = mx[LEN_W-1:0];
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R1: bucket starts empty, zero rate never admits a head
    set_cfg(0, 0, 8, 0, 1, 8);
    do_reset();
    @(negedge clk);
    in_valid = 1'b1;
    in_len = 8'd2;
    repeat (20) @(negedge clk);
    #1;
    check_eq("R1 empty bucket holds head", longint'(in_ready), 0);
    check_eq("R1 nothing forwarded", n_out, 0);
    in_valid = 1'b0;

    // R2 R3 R4: bypass ignores zero rate and large gap
    set_cfg(1, 0, 4, 5, 2, 6);
    do_reset();
    chk_space = 1'b1;
    exp_space = 1;
    send_pkt(4, 1);
    send_pkt(3, 2);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R4 no error on good packets", longint'(len_err), 0);
    check_eq("R2 bypass forwards with zero rate", n_out, 7);
    send_pkt(1, 3);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check_eq("R4 short packet sets error", longint'(len_err), 1);
    send_pkt(7, 4);
    send_pkt(0, 5);
    send_pkt(6, 6);
    send_pkt(2, 7);
    idle_drain();
    check_eq("R3 only in-window flits forwarded", n_out, 15);
    check_eq("R4 error sticky", longint'(len_err), 1);
    chk_space = 1'b0;

    // R6 R7 R8: credit delay and debit
    set_cfg(0, 64, 16, 0, 1, 16);
    do_reset();
    chk_space = 1'b1;
    exp_space = 1;
    send_pkt(4, 10);
    send_pkt(4, 11);
    idle_drain();
    check_eq("R7 two packets seen", heads.size(), 2);
    if (heads.size() == 2) begin
      check_rng("R7 first packet credit delay", heads[0], 16, 18);
      check_rng("R7 debit delays second packet", heads[1] - heads[0], 15, 17);
    end
    check_eq("R4 error clear in regulated run", longint'(len_err), 0);
    chk_space = 1'b0;

    // R5: peak gap inside packets
    set_cfg(0, 256, 32, 3, 1, 16);
    do_reset();
    repeat (20) @(negedge clk);
    chk_space = 1'b1;
    exp_space = 4;
    send_pkt(5, 20);
    send_pkt(5, 21);
    idle_drain();
    check_eq("R5 gap run flit count", n_out, 10);
    chk_space = 1'b0;

    // R6 R9 R10 R3 R4: random regulated with backpressure
    set_cfg(0, 100, 8, 1, 2, 7);
    do_reset();
    rate_chk = 1'b1;
    rand_ready = 1'b1;
    for (int p = 0; p < 40; p++) send_pkt($urandom % 10, 100 + p);
    idle_drain();
    check_eq("R4 random regulated error flag", longint'(len_err), longint'(bad_sent));
    rate_chk = 1'b0;

    // R2 R9 R10 R3: random bypass with backpressure
    set_cfg(1, 0, 1, 7, 1, 8);
    do_reset();
    for (int p = 0; p < 40; p++) send_pkt($urandom % 11, 200 + p);
    idle_drain();
    check_eq("R4 random bypass error flag", longint'(len_err), longint'(bad_sent));
    rand_ready = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R10 actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule